// File: doc/BRIEF.md
# Auxiliary Memory Bank Switch Controller

This block sits between an 8-bit CPU's 16-bit address bus and a 128 KB RAM split into two 64 KB banks, main and auxiliary. Every cycle it classifies the CPU address into a region and forms a 17-bit physical RAM address. The top bit of that address picks the bank, and the lower 16 bits pass through unchanged. Which bank a region uses depends on a set of latched mode bits. Reads and writes of general RAM are steered independently, zero page and stack have a bank select of their own, and a store mode lets the display-page select override the general selects for the text and high-resolution display areas.

The mode bits are set and cleared by soft-switch accesses in the 0xC000 I/O page. A switch access updates the bits on its own clock edge. It is never forwarded to RAM: the whole 0xC000–0xCFFF range reports an invalid physical address. The mode bits can be read back through an 8-bit state port.

Top module: `auxmem_bank_switch`

## Requirements
- R1: When an access is routed to the auxiliary bank, `phys_addr` equals the CPU address plus 0x10000. For main, `phys_addr[16]` is 0. In both cases `phys_addr[15:0]` equals `cpu_addr`.
- R2: A write to 0xC005 sets the write-auxiliary bit and a write to 0xC004 clears it. While the bit is set, writes to 0x0200–0xBFFF go to auxiliary, and reads of that range follow only the read-auxiliary bit.
- R3: A write to 0xC003 sets the read-auxiliary bit and a write to 0xC002 clears it. While the bit is set, reads of 0x0200–0xBFFF come from auxiliary, and writes follow only the write-auxiliary bit.
- R4: Addresses 0x0000–0x01FF ignore the read and write auxiliary bits. A write to 0xC009 sets the alternate zero-page bit and a write to 0xC008 clears it. While the bit is set, both reads and writes of that range go to auxiliary; otherwise they go to main.
- R5: `state_reg` reports the mode bits as bit 7 alternate zero page, bit 6 page 2, bit 5 read auxiliary, bit 4 write auxiliary, bit 3 store mode, bit 2 high-resolution, and bits 1:0 zero. A synchronous reset clears every bit, so `state_reg` reads 0x00 after reset.
- R6: A write to 0xC001 sets the store-mode bit and a write to 0xC000 clears it. An access to 0xC055 sets page 2 and an access to 0xC054 clears it. While store mode is set, accesses to 0x0400–0x07FF go to auxiliary exactly when page 2 is set, whatever the read and write auxiliary bits hold.
- R7: An access to 0xC057 sets the high-resolution bit and an access to 0xC056 clears it. While store mode and high-resolution are both set, accesses to 0x2000–0x3FFF go to auxiliary exactly when page 2 is set. Otherwise that range follows R2 and R3.
- R8: The switches 0xC054–0xC057 act on both reads and writes. The switches 0xC000–0xC00B act on writes only, and a read of them leaves `state_reg` unchanged.
- R9: `phys_valid` is 0 for any address in 0xC000–0xCFFF and whenever `cpu_valid` is 0. Otherwise it is 1.
- R10: The route of an access uses the mode bits held before its clock edge. A switch access changes `state_reg` at that edge, and the new routing applies from the next cycle.
- R11: Addresses 0xD000–0xFFFF always go to main.
- R12: Accesses in the 0xC0xx page other than the listed switches (such as 0xC006, 0xC007, 0xC00A, 0xC00B and 0xC010) leave `state_reg` unchanged. So does any access made while `cpu_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; mode bits update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | 1 for a write access, 0 for a read |
| cpu_valid | input | 1 | Access strobe; 1 when `cpu_addr` and `cpu_we` describe a real access |
| phys_addr | output | 17 | Physical RAM address; bit 16 selects the auxiliary bank |
| phys_valid | output | 1 | 1 when the access is forwarded to RAM |
| state_reg | output | 8 | Mode bits, laid out as in R5 |

## Verification
`phys_addr` and `phys_valid` are combinational and come from the mode bits already latched. The bench drives each access on a falling edge and compares them 2 ns later, within the same cycle and before the rising edge that could change the bits. A switch access shows up in `state_reg` after exactly one rising edge. The bench therefore updates its own mode model right after that edge and compares `state_reg` at the following falling edge. Any late or early update then shows up as a mismatch in either the state or the route of the next access.

// File: rtl/auxsw_pkg.sv
package auxsw_pkg;

   // Mode bit indices inside the latched mode vector
   localparam int MODE_N     = 6;
   localparam int MB_STORE80 = 0;
   localparam int MB_RDAUX   = 1;
   localparam int MB_WRAUX   = 2;
   localparam int MB_ALTZP   = 3;
   localparam int MB_PAGE2   = 4;
   localparam int MB_HIRES   = 5;

   // Same vector viewed by field (MSB first, matches indices above)
   typedef struct packed {
      logic hires;
      logic page2;
      logic altzp;
      logic wraux;
      logic rdaux;
      logic store80;
   } mode_t;

   // Address region classes
   typedef enum logic [2:0] {
      RG_IO    = 3'd0,
      RG_ZP    = 3'd1,
      RG_TEXT  = 3'd2,
      RG_HIRES = 3'd3,
      RG_GEN   = 3'd4,
      RG_HIGH  = 3'd5
   } region_e;

   // Page (address bits 15:8) constants
   localparam logic [7:0] SW_PAGE   = 8'hC0;
   localparam logic [3:0] IO_NIBBLE = 4'hC;
   localparam logic [7:0] ZP_END    = 8'h02;
   localparam logic [7:0] HIGH_BASE = 8'hD0;

endpackage

// File: rtl/auxsw_switch_decode.sv
module auxsw_switch_decode
   import auxsw_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic              cpu_valid,
   output logic [MODE_N-1:0] set_v,
   output logic [MODE_N-1:0] clr_v
);

   localparam int PAGE_LSB = ADDR_W - 8;

   logic [7:0]        lo;
   logic              sw_page;
   logic              bank_hit;
   logic              disp_hit;
   logic [MODE_N-1:0] sel;

   assign lo       = cpu_addr[7:0];
   assign sw_page  = cpu_valid && (cpu_addr[ADDR_W-1:PAGE_LSB] == SW_PAGE);
   // bank switches: write-only, offsets 0x00..0x0B
   assign bank_hit = sw_page && cpu_we && (lo[7:4] == 4'h0) && (lo[3:0] <= 4'hB);
   // display switches: read or write, offsets 0x54..0x57
   assign disp_hit = sw_page && (lo[7:2] == 6'b010101);

   always_comb begin
      sel = '0;
      if (bank_hit) begin
         case (lo[3:1])
            3'd0:    sel[MB_STORE80] = 1'b1;
            3'd1:    sel[MB_RDAUX]   = 1'b1;
            3'd2:    sel[MB_WRAUX]   = 1'b1;
            3'd4:    sel[MB_ALTZP]   = 1'b1;
            default: sel = '0;
         endcase
      end else if (disp_hit) begin
         if (lo[1]) sel[MB_HIRES] = 1'b1;
         else       sel[MB_PAGE2] = 1'b1;
      end
   end

   // odd offset sets, even offset clears
   assign set_v = lo[0] ? sel : '0;
   assign clr_v = lo[0] ? '0  : sel;

endmodule

// File: rtl/auxsw_mode_regs.sv
module auxsw_mode_regs
   import auxsw_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_N-1:0] set_v,
   input  logic [MODE_N-1:0] clr_v,
   output logic [MODE_N-1:0] mode_q
);

   for (genvar i = 0; i < MODE_N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)
            mode_q[i] <= 1'b0;
         else if (set_v[i])
            mode_q[i] <= 1'b1;
         else if (clr_v[i])
            mode_q[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/auxsw_region_map.sv
module auxsw_region_map
   import auxsw_pkg::*;
#(
   parameter int ADDR_W           = 16,
   parameter bit DISPLAY_OVERRIDE = 1'b1
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic              cpu_valid,
   input  mode_t             mode,
   output logic [ADDR_W:0]   phys_addr,
   output logic              phys_valid
);

   localparam int PAGE_LSB = ADDR_W - 8;

   logic [7:0] page;
   region_e    region;
   logic       general_aux;
   logic       ovr_text;
   logic       ovr_hires;
   logic       aux;

   assign page = cpu_addr[ADDR_W-1:PAGE_LSB];

   always_comb begin
      if (page[7:4] == IO_NIBBLE)        region = RG_IO;
      else if (page < ZP_END)            region = RG_ZP;
      else if (page[7:2] == 6'b000001)   region = RG_TEXT;
      else if (page[7:5] == 3'b001)      region = RG_HIRES;
      else if (page >= HIGH_BASE)        region = RG_HIGH;
      else                               region = RG_GEN;
   end

   // display override variant selected at elaboration
   if (DISPLAY_OVERRIDE) begin : g_ovr
      assign ovr_text  = mode.store80;
      assign ovr_hires = mode.store80 & mode.hires;
   end else begin : g_no_ovr
      assign ovr_text  = 1'b0;
      assign ovr_hires = 1'b0;
   end

   assign general_aux = cpu_we ? mode.wraux : mode.rdaux;

   always_comb begin
      case (region)
         RG_ZP:    aux = mode.altzp;
         RG_TEXT:  aux = ovr_text  ? mode.page2 : general_aux;
         RG_HIRES: aux = ovr_hires ? mode.page2 : general_aux;
         RG_GEN:   aux = general_aux;
         default:  aux = 1'b0;
      endcase
   end

   assign phys_addr  = {aux, cpu_addr};
   assign phys_valid = cpu_valid && (region != RG_IO);

endmodule

// File: rtl/auxmem_bank_switch.sv
module auxmem_bank_switch
   import auxsw_pkg::*;
#(
   parameter int ADDR_W           = 16,
   parameter bit DISPLAY_OVERRIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic              cpu_valid,
   output logic [ADDR_W:0]   phys_addr,
   output logic              phys_valid,
   output logic [7:0]        state_reg
);

   initial begin
      assert (ADDR_W == 16)
         else $error("auxmem_bank_switch: ADDR_W must be 16, got %0d", ADDR_W);
   end

   logic [MODE_N-1:0] set_v;
   logic [MODE_N-1:0] clr_v;
   logic [MODE_N-1:0] mode_q;
   mode_t             mode_s;

   auxsw_switch_decode #(.ADDR_W(ADDR_W)) u_dec (
      .cpu_addr  (cpu_addr),
      .cpu_we    (cpu_we),
      .cpu_valid (cpu_valid),
      .set_v     (set_v),
      .clr_v     (clr_v)
   );

   auxsw_mode_regs u_regs (
      .clk    (clk),
      .rst    (rst),
      .set_v  (set_v),
      .clr_v  (clr_v),
      .mode_q (mode_q)
   );

   assign mode_s = mode_t'(mode_q);

   auxsw_region_map #(
      .ADDR_W           (ADDR_W),
      .DISPLAY_OVERRIDE (DISPLAY_OVERRIDE)
   ) u_map (
      .cpu_addr   (cpu_addr),
      .cpu_we     (cpu_we),
      .cpu_valid  (cpu_valid),
      .mode       (mode_s),
      .phys_addr  (phys_addr),
      .phys_valid (phys_valid)
   );

   assign state_reg = {mode_s.altzp, mode_s.page2, mode_s.rdaux, mode_s.wraux,
                       mode_s.store80, mode_s.hires, 2'b00};

endmodule

// File: rtl/auxmem_bank_switch_chk.sv
module auxmem_bank_switch_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_we,
   input logic              cpu_valid,
   input logic [ADDR_W:0]   phys_addr,
   input logic              phys_valid,
   input logic [7:0]        state_reg
);

   logic wr_sw;
   logic rd_sw;
   assign wr_sw = cpu_valid && cpu_we;
   assign rd_sw = cpu_valid && !cpu_we;

   AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
      phys_valid |-> phys_addr[15:0] == cpu_addr); // R1

   AST_WRAUX_SET: assert property (@(posedge clk) disable iff (rst)
      (wr_sw && cpu_addr == 16'hC005) |=> state_reg[4]); // R2

   AST_RDAUX_SET: assert property (@(posedge clk) disable iff (rst)
      (wr_sw && cpu_addr == 16'hC003) |=> state_reg[5]); // R3

   AST_ZP_BANK: assert property (@(posedge clk) disable iff (rst)
      (phys_valid && cpu_addr < 16'h0200) |-> phys_addr[16] == state_reg[7]); // R4

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> state_reg == 8'h00); // R5

   AST_PAGE2_READ: assert property (@(posedge clk) disable iff (rst)
      (rd_sw && cpu_addr == 16'hC055) |=> state_reg[6]); // R8

   AST_BANK_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (rd_sw && cpu_addr >= 16'hC000 && cpu_addr <= 16'hC00B) |=> $stable(state_reg)); // R8

   AST_IO_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr[15:12] == 4'hC) |-> !phys_valid); // R9

   AST_HIGH_MAIN: assert property (@(posedge clk) disable iff (rst)
      (phys_valid && cpu_addr >= 16'hD000) |-> !phys_addr[16]); // R11

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !cpu_valid |=> $stable(state_reg)); // R12

endmodule

bind auxmem_bank_switch auxmem_bank_switch_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/auxmem_bank_switch_test.sv
module auxmem_bank_switch_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_we = 1'b0;
   logic        cpu_valid = 1'b0;
   logic [16:0] phys_addr;
   logic        phys_valid;
   logic [7:0]  state_reg;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench model of the mode bits
   bit m_s80, m_rd, m_wr, m_az, m_p2, m_hr;

   always #5 clk = ~clk;

   auxmem_bank_switch uut (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
      .cpu_valid(cpu_valid), .phys_addr(phys_addr), .phys_valid(phys_valid),
      .state_reg(state_reg)
   );

   function automatic logic [7:0] exp_state();
      return {m_az, m_p2, m_rd, m_wr, m_s80, m_hr, 2'b00};
   endfunction

   function automatic bit exp_aux(input logic [15:0] a, input logic we);
      bit gen;
      gen = we ? m_wr : m_rd;
      if (a < 16'h0200) return m_az;
      if (a >= 16'h0400 && a < 16'h0800) return m_s80 ? m_p2 : gen;
      if (a >= 16'h2000 && a < 16'h4000) return (m_s80 && m_hr) ? m_p2 : gen;
      if (a >= 16'hC000) return 1'b0;
      return gen;
   endfunction

   function automatic string tag_of(input logic [15:0] a, input logic we);
      if (a[15:12] == 4'hC) return "R9";
      if (a < 16'h0200) return "R4";
      if (a >= 16'h0400 && a < 16'h0800 && m_s80) return "R6";
      if (a >= 16'h2000 && a < 16'h4000 && m_s80 && m_hr) return "R7";
      if (a >= 16'hD000) return "R11";
      return we ? "R2" : "R3";
   endfunction

   task automatic model_update(input logic [15:0] a, input logic we, input logic v);
      if (v && a[15:8] == 8'hC0) begin
         if (we) begin
            case (a[7:0])
               8'h00: m_s80 = 0;  8'h01: m_s80 = 1;
               8'h02: m_rd  = 0;  8'h03: m_rd  = 1;
               8'h04: m_wr  = 0;  8'h05: m_wr  = 1;
               8'h08: m_az  = 0;  8'h09: m_az  = 1;
               default: ;
            endcase
         end
         case (a[7:0])
            8'h54: m_p2 = 0;  8'h55: m_p2 = 1;
            8'h56: m_hr = 0;  8'h57: m_hr = 1;
            default: ;
         endcase
      end
   endtask

   task automatic check_state(input string tag);
      n_tests++;
      if (state_reg !== exp_state()) begin
         n_fail++;
         $display("FAIL %s state_reg actual=%02h expected=%02h", tag, state_reg, exp_state());
      end
   endtask

   // one access: state check, drive, same-cycle route check, edge, model update
   task automatic step(input logic [15:0] a, input logic we, input logic v);
      logic [16:0] ea;
      bit          ev;
      @(negedge clk);
      check_state("R5 R8 R10 R12");
      cpu_addr  = a;
      cpu_we    = we;
      cpu_valid = v;
      #2;
      ev = v && (a[15:12] != 4'hC);
      ea = {exp_aux(a, we), a};
      n_tests++;
      if (phys_valid !== ev || (ev && phys_addr !== ea)) begin
         n_fail++;
         $display("FAIL %s R1 R10 addr=%04h we=%0d actual=%0d/%05h expected=%0d/%05h",
                  tag_of(a, we), a, we, phys_valid, phys_addr, ev, ea);
      end
      @(posedge clk);
      model_update(a, we, v);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      cpu_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      {m_s80, m_rd, m_wr, m_az, m_p2, m_hr} = '0;
      check_state("R5 reset");
   endtask

   function automatic logic [15:0] pick_switch(input int k);
      return (k < 12) ? 16'(16'hC000 + k) : 16'(16'hC054 + (k - 12));
   endfunction

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check_state("R5 reset");

      // R2: write aux then general write/read
      step(16'hC005, 1, 1);
      step(16'h1234, 1, 1);               // expect 0x11234 (R1)
      step(16'h1234, 0, 1);               // read from main
      // R8: read of bank switch ignored
      step(16'hC003, 0, 1);
      step(16'h1234, 0, 1);
      // R3
      step(16'hC004, 1, 1);
      step(16'hC003, 1, 1);
      step(16'h0300, 0, 1);
      step(16'h0300, 1, 1);
      // R4
      step(16'h01FF, 1, 1);
      step(16'hC009, 1, 1);
      step(16'h0000, 0, 1);
      step(16'h01FF, 1, 1);
      // R6 and R7
      step(16'hC001, 1, 1);
      step(16'h0400, 1, 1);               // page2 clear: main
      step(16'hC055, 0, 1);
      step(16'h07FF, 1, 1);
      step(16'h2000, 1, 1);               // hires clear: general
      step(16'hC057, 0, 1);
      step(16'h3FFF, 0, 1);
      step(16'hC054, 1, 1);
      step(16'h2000, 0, 1);
      // R11, R9, R12
      step(16'hD000, 1, 1);
      step(16'hFFFF, 0, 1);
      step(16'hCFFF, 1, 1);
      step(16'hC006, 1, 1);
      step(16'hC00B, 1, 1);
      step(16'hC010, 1, 1);
      step(16'hC009, 1, 0);               // idle: ignored
      step(16'hC008, 1, 1);
      step(16'h0100, 1, 1);

      do_reset();

      for (int i = 0; i < 4000; i++) begin
         int          r;
         logic [15:0] a;
         r = int'($urandom % 8);
         case (r)
            0, 1, 2: a = pick_switch(int'($urandom % 16));
            3:       a = {8'hC0, 8'($urandom)};
            4:       a = 16'($urandom % 16'h0200);
            5:       a = ($urandom % 2 != 0) ? 16'(16'h0400 + $urandom % 16'h0400)
                                             : 16'(16'h2000 + $urandom % 16'h2000);
            default: a = 16'($urandom);
         endcase
         step(a, 1'($urandom), ($urandom % 8) != 0);
         if (i == 2000) do_reset();
      end

      @(negedge clk);
      check_state("R5 R10 final");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule